// File: doc/BRIEF.md
# Inter-processor doorbell interrupt router

This block sits in front of one receiving processor and gathers doorbell interrupts raised by other processor clients. Each doorbell source is a client/signal pair. The pair is named by a 32-bit identifier word that holds the client number in bits 31:16 and the signal number in bits 15:0. For every pair the block keeps a pending bit and an enable bit. A rising edge on the pair's external input sets the pending bit. Software then reads, clears, masks and unmasks pairs by writing identifier words to a small register bus.

Software handles interrupts by looping on the receive register while the summary interrupt is high. Each read returns the identifier of one pending, enabled pair, and the lowest-numbered pair comes first. Software clears that pair through the clear register and reads again, until the read returns the all-ones sentinel. Writing an identifier to the send register raises a doorbell toward another client. The block shows this as a one-cycle outbound pulse that carries the word. The block is built for 17 clients with 4 signals each by default.

Top module: `doorbell_router`

## Requirements
- R1: After reset the summary interrupt is low and the outbound pulse is low. A read of the receive register returns 0xFFFFFFFF.
- R2: A write of an in-range identifier word to offset 0x0C produces `sendValid` high for exactly one cycle, in the cycle after the write. During that cycle `sendWord` equals the written word: client in bits 31:16, signal in bits 15:0.
- R3: A rising edge on `sigIn[c*SIGNALS+s]` sets the pending bit of pair (c,s). An input held high after its pair is cleared does not set the pending bit again.
- R4: A read at offset 0x10 returns its data on `rdData` in the next cycle. The data is the identifier of the pending, enabled pair with the lowest client number, and within that client the lowest signal number. If no such pair exists the data is 0xFFFFFFFF. A read does not clear the pending bit.
- R5: A write of an identifier word to offset 0x1C clears the pending bit of that pair.
- R6: A write to offset 0x14 enables the named pair and a write to offset 0x18 disables it. A disabled pair still records pending. That pending state is reported once the pair is enabled again.
- R7: `irqOut` is high exactly while at least one enabled pair is pending.
- R8: A write to offset 0x38 with bit 0 set clears every pending and every enable bit. A write there with bit 0 clear has no effect.
- R9: A write whose client number is 17 or more, or whose signal number is 4 or more, is ignored by the send, enable, disable and clear registers.
- R10: When a rising input edge and a clear of the same pair occur in the same cycle, the pair ends up pending.
- R11: Writes to any other offset have no effect. Reads of any offset other than 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write data (identifier word or clear-all flag) |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| sigIn | input | 68 | Incoming doorbell lines, one per pair, index client*4+signal |
| irqOut | output | 1 | Level-sensitive, active-high summary interrupt |
| sendValid | output | 1 | One-cycle outbound doorbell pulse |
| sendWord | output | 32 | Identifier carried by the outbound pulse |

## Verification
The receive ordering is tried with three pairs raised out of order across two clients. The clears then walk them out one at a time, which separates client-first from signal-first priority and shows that reads leave state intact. A held-high input is cleared while still asserted, which tells edge capture apart from level capture. A set and a clear are made to hit the same pair in one cycle. Identifiers whose signal number aliases onto a valid pair index, and writes to unmapped offsets, show whether the range and address decoding really reject them.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 16;

  localparam logic [ADDR_W-1:0] OFF_SEND   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RECV   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_UNMASK = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_WIPE   = 8'h38;

  // actions the control hands to the datapath for the current cycle
  typedef struct packed {
    logic doSend;
    logic doClear;
    logic doUnmask;
    logic doMask;
    logic doWipe;
    logic doRdRecv;
    logic doRdOther;
  } dbStrobe_t;
endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int unsigned CLIENTS = 17,
  parameter int unsigned SIGNALS = 4,
  localparam int unsigned PAIRS  = CLIENTS * SIGNALS,
  localparam int unsigned IDX_W  = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output dbStrobe_t         strb,
  output logic [IDX_W-1:0]  pairIdx,
  output logic              sendValid,
  output logic [WORD_W-1:0] sendWord
);
  logic [ID_W-1:0] clientId;
  logic [ID_W-1:0] signalId;
  logic            idOk;
  logic [31:0]     idxFull;

  // identifier unpack and range check
  always_comb begin
    clientId = wrData[WORD_W-1:ID_W];
    signalId = wrData[ID_W-1:0];
    idOk     = (32'(clientId) < CLIENTS) && (32'(signalId) < SIGNALS);
    idxFull  = 32'(clientId) * SIGNALS + 32'(signalId);
    pairIdx  = idxFull[IDX_W-1:0];
  end

  // address decode into strobes
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (addr)
        OFF_SEND:   strb.doSend   = idOk;
        OFF_CLEAR:  strb.doClear  = idOk;
        OFF_UNMASK: strb.doUnmask = idOk;
        OFF_MASK:   strb.doMask   = idOk;
        OFF_WIPE:   strb.doWipe   = wrData[0];
        default:    ;
      endcase
    end
    if (rdEn) begin
      strb.doRdRecv  = (addr == OFF_RECV);
      strb.doRdOther = (addr != OFF_RECV);
    end
  end

  // outbound doorbell pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendValid <= 1'b0;
      sendWord  <= '0;
    end else begin
      sendValid <= strb.doSend;
      if (strb.doSend) sendWord <= wrData;
    end
  end

  a_r11_one_write_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doSend, strb.doClear, strb.doUnmask, strb.doMask, strb.doWipe}));

  a_r2_send_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sendValid) |-> ($past(wrEn) && $past(addr) == OFF_SEND));

  a_r9_send_range: assert property (@(posedge clk) disable iff (!rstN)
    sendValid |-> ((32'(sendWord[WORD_W-1:ID_W]) < CLIENTS) &&
                   (32'(sendWord[ID_W-1:0]) < SIGNALS)));
endmodule

// File: rtl/doorbell_dp.sv
module doorbell_dp
  import doorbell_pkg::*;
#(
  parameter int unsigned CLIENTS = 17,
  parameter int unsigned SIGNALS = 4,
  localparam int unsigned PAIRS  = CLIENTS * SIGNALS,
  localparam int unsigned IDX_W  = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbStrobe_t         strb,
  input  logic [IDX_W-1:0]  pairIdx,
  input  logic [PAIRS-1:0]  sigIn,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut
);
  logic [PAIRS-1:0]  sigPrev;
  logic [PAIRS-1:0]  riseVec;
  logic [PAIRS-1:0]  pend;
  logic [PAIRS-1:0]  en;
  logic [PAIRS-1:0]  active;
  logic [PAIRS-1:0]  selMask;
  logic              hit;
  int unsigned       hitIdx;
  logic [WORD_W-1:0] recvWord;

  always_ff @(posedge clk) begin
    if (!rstN) sigPrev <= '0;
    else       sigPrev <= sigIn;
  end

  assign riseVec = sigIn & ~sigPrev;
  assign selMask = PAIRS'(1) << pairIdx;

  // one pending/enable cell per client/signal pair
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic clrHit;
    assign clrHit = strb.doWipe || (strb.doClear && selMask[p]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend[p] <= 1'b0;
        en[p]   <= 1'b0;
      end else begin
        // an incoming edge outranks any clear in the same cycle
        pend[p] <= riseVec[p] || (pend[p] && !clrHit);
        if (strb.doWipe)                      en[p] <= 1'b0;
        else if (strb.doUnmask && selMask[p]) en[p] <= 1'b1;
        else if (strb.doMask && selMask[p])   en[p] <= 1'b0;
      end
    end
  end

  assign active = pend & en;
  assign irqOut = |active;

  // lowest index wins: lowest client, then lowest signal
  always_comb begin
    hit    = 1'b0;
    hitIdx = 0;
    for (int i = PAIRS - 1; i >= 0; i--) begin
      if (active[i]) begin
        hit    = 1'b1;
        hitIdx = i;
      end
    end
  end

  always_comb begin
    int unsigned cNum;
    int unsigned sNum;
    cNum = hitIdx / SIGNALS;
    sNum = hitIdx % SIGNALS;
    recvWord = hit ? {cNum[ID_W-1:0], sNum[ID_W-1:0]} : '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdData <= '0;
    else if (strb.doRdRecv)  rdData <= recvWord;
    else if (strb.doRdOther) rdData <= '0;
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|riseVec) |=> ((pend & $past(riseVec)) == $past(riseVec)));

  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doClear && !riseVec[pairIdx]) |=> !pend[$past(pairIdx)]);

  a_r8_wipe_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWipe |=> (en == '0));

  a_r4_sentinel: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRdRecv && !irqOut) |=> (rdData == '1));

  a_r4_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRdRecv && !strb.doClear && !strb.doWipe) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/doorbell_router.sv
module doorbell_router
  import doorbell_pkg::*;
#(
  parameter int unsigned CLIENTS = 17,
  parameter int unsigned SIGNALS = 4,
  localparam int unsigned PAIRS  = CLIENTS * SIGNALS,
  localparam int unsigned IDX_W  = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  input  logic [PAIRS-1:0]  sigIn,
  output logic              irqOut,
  output logic              sendValid,
  output logic [WORD_W-1:0] sendWord
);
  dbStrobe_t        strb;
  logic [IDX_W-1:0] pairIdx;

  doorbell_ctrl #(.CLIENTS(CLIENTS), .SIGNALS(SIGNALS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strb(strb), .pairIdx(pairIdx),
    .sendValid(sendValid), .sendWord(sendWord)
  );

  doorbell_dp #(.CLIENTS(CLIENTS), .SIGNALS(SIGNALS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pairIdx(pairIdx),
    .sigIn(sigIn), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_doorbell_router.sv
`timescale 1ns/1ps
module sim_doorbell_router;
  localparam int NS = 4;
  localparam int NP = 68;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NP-1:0] sigIn = '0;
  logic irqOut, sendValid;
  logic [31:0] sendWord;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  doorbell_router u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sigIn(sigIn), .irqOut(irqOut),
    .sendValid(sendValid), .sendWord(sendWord)
  );

  function automatic logic [31:0] pk(int c, int s);
    return {c[15:0], s[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; v = rdData;
  endtask

  task automatic pulse(int idx);
    @(negedge clk); sigIn[idx] = 1'b1;
    @(negedge clk); sigIn[idx] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irqOut), 0);
    chk("R1 send", 32'(sendValid), 0);
    rd(8'h10, v); chk("R1 recv", v, NONE);
  endtask

  task automatic t_send();
    @(negedge clk); wrEn = 1'b1; addr = 8'h0C; wrData = pk(2, 3);
    @(negedge clk); wrEn = 1'b0;
    chk("R2 pulse", 32'(sendValid), 1);
    chk("R2 word", sendWord, 32'h0002_0003);
    @(negedge clk);
    chk("R2 one cycle", 32'(sendValid), 0);
    @(negedge clk); wrEn = 1'b1; addr = 8'h0C; wrData = pk(17, 0);
    @(negedge clk); wrEn = 1'b0;
    chk("R9 send range", 32'(sendValid), 0);
  endtask

  task automatic t_masked_pending();
    logic [31:0] v;
    wr(8'h38, 1);
    pulse(2*NS+2);
    chk("R6 masked irq", 32'(irqOut), 0);
    rd(8'h10, v); chk("R6 masked recv", v, NONE);
    wr(8'h14, pk(2, 2));
    chk("R7 irq", 32'(irqOut), 1);
    rd(8'h10, v); chk("R6 late report", v, pk(2, 2));
    rd(8'h10, v); chk("R4 read keeps", v, pk(2, 2));
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(8'h38, 1);
    wr(8'h14, pk(5, 0)); wr(8'h14, pk(5, 1)); wr(8'h14, pk(3, 3));
    pulse(5*NS+1); pulse(3*NS+3); pulse(5*NS+0);
    rd(8'h10, v); chk("R4 client first", v, pk(3, 3));
    wr(8'h1C, pk(3, 3));
    rd(8'h10, v); chk("R4 signal order", v, pk(5, 0));
    wr(8'h1C, pk(5, 0));
    rd(8'h10, v); chk("R5 clear", v, pk(5, 1));
    wr(8'h1C, pk(5, 1));
    rd(8'h10, v); chk("R4 drained", v, NONE);
    chk("R7 irq low", 32'(irqOut), 0);
  endtask

  task automatic t_held();
    logic [31:0] v;
    wr(8'h38, 1);
    wr(8'h14, pk(1, 0));
    @(negedge clk); sigIn[1*NS] = 1'b1;
    @(negedge clk);
    rd(8'h10, v); chk("R3 edge sets", v, pk(1, 0));
    wr(8'h1C, pk(1, 0));
    rd(8'h10, v); chk("R3 held no repend", v, NONE);
    @(negedge clk); sigIn[1*NS] = 1'b0;
    pulse(1*NS);
    rd(8'h10, v); chk("R3 new edge", v, pk(1, 0));
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h38, 1);
    wr(8'h14, pk(4, 2));
    pulse(4*NS+2);
    chk("R7 irq on", 32'(irqOut), 1);
    wr(8'h18, pk(4, 2));
    chk("R6 masked", 32'(irqOut), 0);
    rd(8'h10, v); chk("R6 masked recv", v, NONE);
    wr(8'h14, pk(4, 2));
    chk("R6 pending kept", 32'(irqOut), 1);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(8'h38, 1);
    wr(8'h14, pk(6, 1));
    @(negedge clk); wrEn = 1'b1; addr = 8'h1C; wrData = pk(6, 1); sigIn[6*NS+1] = 1'b1;
    @(negedge clk); wrEn = 1'b0; sigIn[6*NS+1] = 1'b0;
    rd(8'h10, v); chk("R10 set wins", v, pk(6, 1));
  endtask

  task automatic t_range();
    logic [31:0] v;
    wr(8'h38, 1);
    wr(8'h14, pk(0, 4));
    pulse(1*NS);
    chk("R9 enable range", 32'(irqOut), 0);
    wr(8'h14, pk(1, 0));
    wr(8'h1C, pk(0, 4));
    rd(8'h10, v); chk("R9 clear range", v, pk(1, 0));
  endtask

  task automatic t_wipe();
    logic [31:0] v;
    wr(8'h38, 1);
    wr(8'h14, pk(16, 3));
    pulse(16*NS+3);
    wr(8'h38, 0);
    chk("R8 bit0 clear no effect", 32'(irqOut), 1);
    rd(8'h10, v); chk("R8 last pair", v, pk(16, 3));
    wr(8'h38, 1);
    chk("R8 wipe", 32'(irqOut), 0);
    pulse(16*NS+3);
    chk("R8 enable wiped", 32'(irqOut), 0);
    wr(8'h14, pk(16, 3));
    chk("R8 pending re-set", 32'(irqOut), 1);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(8'h38, 1);
    pulse(0);
    wr(8'h20, pk(0, 0));
    chk("R11 stray write", 32'(irqOut), 0);
    rd(8'h20, v); chk("R11 stray read", v, 0);
    rd(8'h0C, v); chk("R11 send read", v, 0);
    wr(8'h14, pk(0, 0));
    rd(8'h10, v); chk("R11 recv", v, pk(0, 0));
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_send();
    t_masked_pending();
    t_priority();
    t_held();
    t_mask();
    t_race();
    t_range();
    t_wipe();
    t_addr();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule